// File: doc/BRIEF.md
# Quadrature Encoder Decoder with Illegal-Step Repair

This block turns the two square-wave channels of an incremental biphase encoder into a signed position count. Both channels first pass through a two-flop synchroniser. A four-state machine then tracks which Gray phase the encoder is in. Each legal move to a neighbouring phase counts one edge, up or down, so one full mechanical cycle moves the count by four.

When both channels appear to change together, the machine cannot tell which edge came first. It raises a one-cycle error pulse and steps one phase in the direction of the last legal move. If the channels then stay where they are, the following cycle completes the second step. A skipped phase therefore costs no position. The host can zero the count at any time with a clear input. The clear leaves the tracked phase and the direction untouched.

The machine has four states. PH_00 holds when A=0 and B=0, PH_01 when A=0 and B=1, PH_11 when A=1 and B=1, and PH_10 when A=1 and B=0. Each cycle takes one of four transitions. HOLD applies when the sampled phase equals the state. STEP_FWD applies when the sampled phase is the forward neighbour. STEP_REV applies when it is the reverse neighbour. SKIP applies when it is the diagonal phase, and it moves the state one neighbour in the remembered direction.

Top module: `quad_decoder`

## Requirements
- R1: While reset is high at a clock edge, the next outputs are count 0, dir_fwd 1 and err 0. The synchroniser and the tracked phase return to 00.
- R2: The phase is {A,B}, with A as the MSB. A step along 00→01→11→10→00 (STEP_FWD) adds one to the count and sets dir_fwd to 1.
- R3: A step along 00→10→11→01→00 (STEP_REV) subtracts one from the count and sets dir_fwd to 0.
- R4: Every legal edge on either channel is counted, so eight clean forward cycles starting from 0 read 32.
- R5: dir_fwd shows the direction of the last legal step. A SKIP leaves it unchanged.
- R6: A move to the diagonal phase raises err for exactly one cycle. The tracked phase moves to the neighbour in the remembered direction, and the count changes by one in that direction. If the channels stay on the diagonal phase, the next cycle takes the second step with no error, for a net change of two.
- R7: A one-sample forward glitch followed at once by a return gives a net count change of zero.
- R8: A clear at a clock edge makes the count 0 after that edge, even if a step occurs in the same cycle. The tracked phase and dir_fwd are unaffected.
- R9: When the sampled phase equals the tracked phase, the count, the phase and dir_fwd stay unchanged, and err is 0.
- R10: The count is a CNT_W-bit two's-complement value that wraps: one reverse step from 0 reads all ones, and one forward step from all ones reads 0.
- R11: A channel change applied before clock edge 1 changes the count only after edge 3. The count does not move after edges 1 or 2, because of the two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Host clear of the count, synchronous |
| ch_a | input | 1 | Encoder channel A (phase MSB), asynchronous |
| ch_b | input | 1 | Encoder channel B (phase LSB), asynchronous |
| count | output | CNT_W | Signed edge count, wraps |
| dir_fwd | output | 1 | 1 after a forward step, 0 after a reverse step |
| err | output | 1 | One-cycle pulse on a diagonal move |

## Verification
The assertions rely on reset being held for at least two cycles. They also assume the channels sit at phase 00 during reset, so that the synchroniser and the tracked phase agree from the first cycle. The repair assertions hold for any channel behaviour. A two-step repair only completes when the diagonal phase is held for at least two samples, so the stimulus holds most phases for four cycles. Glitches are deliberately one sample long, to probe the one-step cancellation. Inputs change only a fixed delay after the falling edge, well clear of the sampling edge.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_t;

    typedef enum logic {
        DIR_REV = 1'b0,
        DIR_FWD = 1'b1
    } dir_t;

    function automatic phase_t fwd_of(input phase_t p);
        phase_t r;
        unique case (p)
            PH_00: r = PH_01;
            PH_01: r = PH_11;
            PH_11: r = PH_10;
            PH_10: r = PH_00;
        endcase
        return r;
    endfunction

    function automatic phase_t rev_of(input phase_t p);
        phase_t r;
        unique case (p)
            PH_00: r = PH_10;
            PH_10: r = PH_11;
            PH_11: r = PH_01;
            PH_01: r = PH_00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[LAST];

endmodule

// File: rtl/qdec_tracker.sv
module qdec_tracker
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] smp,
    output logic       up,
    output logic       dn,
    output logic       err_q,
    output logic       dir_fwd
);
    phase_t trk_q, trk_d;
    dir_t   dir_q, dir_d;
    phase_t smp_p;
    logic   skip;

    assign smp_p = phase_t'(smp);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= PH_00;
            dir_q <= DIR_FWD;
            err_q <= 1'b0;
        end else begin
            trk_q <= trk_d;
            dir_q <= dir_d;
            err_q <= skip;
        end
    end

    // transition and step outputs
    always_comb begin
        trk_d = trk_q;
        dir_d = dir_q;
        up    = 1'b0;
        dn    = 1'b0;
        skip  = 1'b0;
        if (smp_p == trk_q) begin
            // HOLD
        end else if (smp_p == fwd_of(trk_q)) begin
            up    = 1'b1;
            trk_d = smp_p;
            dir_d = DIR_FWD;
        end else if (smp_p == rev_of(trk_q)) begin
            dn    = 1'b1;
            trk_d = smp_p;
            dir_d = DIR_REV;
        end else begin
            skip = 1'b1;
            unique case (dir_q)
                DIR_FWD: begin up = 1'b1; trk_d = fwd_of(trk_q); end
                DIR_REV: begin dn = 1'b1; trk_d = rev_of(trk_q); end
            endcase
        end
    end

    assign dir_fwd = (dir_q == DIR_FWD);

    // R9: idle input leaves phase and direction alone
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (smp_p == trk_q) |=> (trk_q == $past(trk_q) && dir_q == $past(dir_q)));

    // R6: repair moves exactly one neighbour
    a_r6_skip_one_neighbour: assert property (@(posedge clk) disable iff (rst)
        skip |=> ($countones(trk_q ^ $past(trk_q)) == 1));

    // R5: repair keeps the remembered direction
    a_r5_skip_keeps_dir: assert property (@(posedge clk) disable iff (rst)
        skip |=> (dir_q == $past(dir_q)));

    // R6: error output follows a skip by one cycle
    a_r6_err_after_skip: assert property (@(posedge clk) disable iff (rst)
        skip |=> err_q);

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             up,
    input  logic             dn,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (up)     cnt_q <= cnt_q + ONE;
        else if (dn)     cnt_q <= cnt_q - ONE;
    end

    // R2: never both directions in one cycle
    a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up, dn}));

    // R8: clear wins
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R10: wrap on overflow
    a_r10_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (!clr && up && cnt_q == '1) |=> (cnt_q == '0));

    // R10: wrap on underflow
    a_r10_wrap_dn: assert property (@(posedge clk) disable iff (rst)
        (!clr && dn && cnt_q == '0) |=> (cnt_q == '1));

endmodule

// File: rtl/quad_decoder.sv
module quad_decoder #(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ch_a,
    input  logic             ch_b,
    output logic [CNT_W-1:0] count,
    output logic             dir_fwd,
    output logic             err
);
    logic [1:0] smp;
    logic       up, dn;

    qdec_sync #(.STAGES(SYNC_DEPTH), .W(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ch_a, ch_b}),
        .dout (smp)
    );

    qdec_tracker u_trk (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .up      (up),
        .dn      (dn),
        .err_q   (err),
        .dir_fwd (dir_fwd)
    );

    qdec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .up    (up),
        .dn    (dn),
        .cnt_q (count)
    );

    // R6: error pulse never lasts past a clean step
    a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
        (err && $stable(smp) && $past(smp) == smp) |=> !err);

endmodule

// File: tb/quad_decoder_tb.sv
`timescale 1ns/1ps
module quad_decoder_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic ch_a = 1'b0;
    logic ch_b = 1'b0;
    logic [W-1:0] count;
    logic dir_fwd, err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    quad_decoder #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .ch_a(ch_a), .ch_b(ch_b),
        .count(count), .dir_fwd(dir_fwd), .err(err)
    );

    // phase index on the forward circle: 00->0, 01->1, 11->2, 10->3
    function automatic int idx_of(input logic [1:0] v);
        case (v)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [1:0] code_of(input int i);
        case (((i % 4) + 4) % 4)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    // behavioural reference model
    logic [1:0] pipe [$];
    int  m_trk = 0;
    int  m_cnt = 0;
    bit  m_dir = 1;
    bit  m_err = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            pipe = '{2'b00, 2'b00};
            m_trk = 0; m_cnt = 0; m_dir = 1; m_err = 0;
        end else begin
            logic [1:0] v;
            int d, delta;
            pipe.push_back({ch_a, ch_b});
            v = pipe.pop_front();
            d = (idx_of(v) - m_trk + 4) % 4;
            delta = 0;
            m_err = 0;
            if (d == 1) begin delta = 1; m_dir = 1; m_trk = idx_of(v); end
            else if (d == 3) begin delta = -1; m_dir = 0; m_trk = idx_of(v); end
            else if (d == 2) begin
                m_err = 1;
                delta = m_dir ? 1 : -1;
                m_trk = (m_trk + delta + 4) % 4;
            end
            if (clr) m_cnt = 0;
            else m_cnt = m_cnt + delta;
            // per-cycle comparison
            chk(count == W'(m_cnt), "R2/R3 count model", int'(count), int'(W'(m_cnt)));
            chk(dir_fwd == m_dir, "R5 direction model", int'(dir_fwd), int'(m_dir));
            chk(err == m_err, "R6 error model", int'(err), int'(m_err));
        end
    end

    int cur = 0;

    task automatic drive(input int i, input int hold);
        @(negedge clk); #1;
        {ch_a, ch_b} = code_of(i);
        cur = ((i % 4) + 4) % 4;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(count == 0, "R1 reset count", int'(count), 0);
        chk(dir_fwd == 1, "R1 reset dir", int'(dir_fwd), 1);
        chk(err == 0, "R1 reset err", int'(err), 0);

        // R11 latency
        @(negedge clk); #1 {ch_a, ch_b} = code_of(1); cur = 1;
        @(negedge clk); chk(count == 0, "R11 after edge 1", int'(count), 0);
        @(negedge clk); chk(count == 0, "R11 after edge 2", int'(count), 0);
        @(negedge clk); chk(count == 1, "R11 after edge 3", int'(count), 1);
        drive(0, 4);
        chk(count == 0, "R3 reverse step", int'(count), 0);
        chk(dir_fwd == 0, "R3 dir after reverse", int'(dir_fwd), 0);

        // R4 eight clean forward cycles
        for (int i = 1; i <= 32; i++) drive(i, 4);
        chk(count == 32, "R4 eight cycles", int'(count), 32);
        chk(dir_fwd == 1, "R2 dir forward", int'(dir_fwd), 1);

        // R9 idle
        repeat (10) @(negedge clk);
        chk(count == 32, "R9 idle count", int'(count), 32);
        chk(err == 0, "R9 idle err", int'(err), 0);

        // R3 reverse two cycles
        for (int i = 1; i <= 8; i++) drive(cur - 1, 4);
        chk(count == 24, "R3 reverse cycles", int'(count), 24);

        // R8 clear keeps dir
        @(negedge clk); #1 clr = 1'b1;
        @(negedge clk); #1 clr = 1'b0;
        chk(count == 0, "R8 clear", int'(count), 0);
        chk(dir_fwd == 0, "R8 dir kept", int'(dir_fwd), 0);

        // R10 wrap
        drive(cur - 1, 4);
        chk(count == 16'hFFFF, "R10 underflow", int'(count), 'hFFFF);
        drive(cur + 1, 4);
        chk(count == 0, "R10 overflow", int'(count), 0);

        // R6 forward skip: err one cycle, net +2
        base = int'(count);
        @(negedge clk); #1 {ch_a, ch_b} = code_of(cur + 2); cur = (cur + 2) % 4;
        repeat (3) @(negedge clk);
        chk(err == 1, "R6 err pulse", int'(err), 1);
        chk(count == W'(base + 1), "R6 first repair step", int'(count), base + 1);
        @(negedge clk);
        chk(err == 0, "R6 err one cycle", int'(err), 0);
        chk(count == W'(base + 2), "R6 net two", int'(count), base + 2);
        chk(dir_fwd == 1, "R5 skip keeps fwd", int'(dir_fwd), 1);
        repeat (3) @(negedge clk);

        // R6 reverse skip
        drive(cur - 1, 4);
        base = int'(count);
        drive(cur - 2, 6);
        chk(count == W'(base - 2), "R6 reverse net two", int'(count), base - 2);
        chk(dir_fwd == 0, "R5 skip keeps rev", int'(dir_fwd), 0);

        // R8 clear coincides with a step
        @(negedge clk); #1 {ch_a, ch_b} = code_of(cur - 1); cur = (cur + 3) % 4;
        @(negedge clk);
        @(negedge clk); #1 clr = 1'b1;
        @(negedge clk); #1 clr = 1'b0;
        chk(count == 0, "R8 clear beats step", int'(count), 0);
        repeat (3) @(negedge clk);
        chk(count == 0, "R8 state kept", int'(count), 0);

        // R4/R6 eight forward cycles with skips
        drive(cur + 1, 4);
        @(negedge clk); #1 clr = 1'b1;
        @(negedge clk); #1 clr = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (c % 2 == 1) begin
                drive(cur + 2, 4);
                drive(cur + 1, 4);
                drive(cur + 1, 4);
            end else begin
                for (int s = 0; s < 4; s++) drive(cur + 1, 4);
            end
        end
        chk(count == 32, "R4 eight cycles with skips", int'(count), 32);

        // R7 glitch
        base = int'(count);
        drive(cur + 1, 1);
        drive(cur - 1, 5);
        chk(count == W'(base), "R7 glitch net zero", int'(count), base);
        chk(dir_fwd == 0, "R7 dir after glitch", int'(dir_fwd), 0);

        // R1 reset mid-run
        #1 {ch_a, ch_b} = 2'b00; cur = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(count == 0, "R1 reset again", int'(count), 0);
        chk(dir_fwd == 1, "R1 dir again", int'(dir_fwd), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule